// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small accumulator machine that runs every instruction as a fixed sequence of four clock cycles. It keeps a 16-bit accumulator, an 8-bit program counter, an address register that drives the memory address, a data staging register, an instruction register and an 8-bit output port register. It works with an external single-port synchronous memory of 256 words of 16 bits. The memory returns read data one cycle after it samples the address.

An instruction word carries its opcode in bits 15:8 and an address or immediate field in bits 7:0. Each instruction goes through four states. In fetch, the address register holds the program counter and the counter advances. In IR load, the returned word is staged and its low byte is steered onto the address register. In decode, the operand read is under way and the staged word moves into the instruction register. In execute, the operand is available and the result is committed. At the end of execute the address register is loaded with the next program counter, so the next instruction word is already being read when fetch begins.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held (active-low `rst_n`), and in the first cycle after it, `mem_addr` is 0x00, `mem_we` is 0 and `out_port` is 0x00. The accumulator starts at zero, so a STORE at location 0x00 writes 0x0000.
- R2: Execution starts at address 0x00 and each instruction takes exactly four cycles. In cycles 1 and 2 after reset `mem_addr` shows the program counter. In cycles 3 and 4 it shows the instruction's low byte. In cycle 5 it shows the next program counter.
- R3: LOAD (0x02) copies mem[field] into the accumulator. STORE (0x01) drives the accumulator on `mem_wdata` with `mem_we` high for exactly one cycle, the fourth cycle of the instruction, at address field.
- R4: ADD (0x00) and SUB (0x05) set the accumulator to accumulator plus or minus mem[field], modulo 2^16.
- R5: XOR (0x06), OR (0x07) and AND (0x08) combine the accumulator with mem[field] bit by bit.
- R6: ADDI (0x0B) adds the 8-bit field, zero-extended to 16 bits, to the accumulator.
- R7: SHL (0x0D) and SHR (0x0E) shift the accumulator left or right, filling with zeros, by the amount in field bits 3:0.
- R8: JUMP (0x03) always loads the program counter with the field.
- R9: JNEG (0x04), JPOS (0x09) and JZERO (0x0A) treat the accumulator as signed. They jump when it is below zero, above zero or equal to zero respectively. Otherwise execution continues at the next word.
- R10: OUT (0x0C) copies accumulator bits 7:0 to `out_port`. No other instruction changes `out_port`.
- R11: Opcodes 0x0F to 0xFF change neither the accumulator, memory nor `out_port`, and execution continues at the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Memory address, driven by the address register |
| mem_wdata | output | 16 | Write data, the accumulator |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| out_port | output | 8 | Output port register |

## Verification
Two things happen in the same execute cycle. A taken branch overrides the incremented program counter, and the address register is loaded with the address of the next fetch. An error in either shows up as the wrong instruction running next. The bench provokes this by running each conditional branch on signed boundary values (zero, one, 0x7FFF, 0x8000, 0xFFFF). The two possible paths store different marker words to one location, and the bench reads that location back. A STORE also falls in a cycle where the memory is sampling a read at the same address. The bench judges this by the exact cycle and address of the write strobe, and by the stored value read back from memory.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int ACC_W   = 16;
    localparam int ADR_W   = 8;
    localparam int OPC_W   = 8;
    localparam int OUT_W   = 8;
    localparam int SHAMT_W = 4;

    localparam logic [OPC_W-1:0] OP_ADD   = 8'h00;
    localparam logic [OPC_W-1:0] OP_STORE = 8'h01;
    localparam logic [OPC_W-1:0] OP_LOAD  = 8'h02;
    localparam logic [OPC_W-1:0] OP_JUMP  = 8'h03;
    localparam logic [OPC_W-1:0] OP_JNEG  = 8'h04;
    localparam logic [OPC_W-1:0] OP_SUB   = 8'h05;
    localparam logic [OPC_W-1:0] OP_XOR   = 8'h06;
    localparam logic [OPC_W-1:0] OP_OR    = 8'h07;
    localparam logic [OPC_W-1:0] OP_AND   = 8'h08;
    localparam logic [OPC_W-1:0] OP_JPOS  = 8'h09;
    localparam logic [OPC_W-1:0] OP_JZERO = 8'h0A;
    localparam logic [OPC_W-1:0] OP_ADDI  = 8'h0B;
    localparam logic [OPC_W-1:0] OP_OUT   = 8'h0C;
    localparam logic [OPC_W-1:0] OP_SHL   = 8'h0D;
    localparam logic [OPC_W-1:0] OP_SHR   = 8'h0E;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_IRLD   = 2'd1,
        ST_DECODE = 2'd2,
        ST_EXEC   = 2'd3
    } cpu_state_e;

    typedef struct packed {
        cpu_state_e        state;
        logic [ADR_W-1:0]  pc;
        logic [ADR_W-1:0]  mar;
        logic [ACC_W-1:0]  mdr;
        logic [ACC_W-1:0]  ir;
        logic [ACC_W-1:0]  ac;
        logic [OUT_W-1:0]  outr;
    } cpu_regs_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = ACC_W,
    parameter int OW = OPC_W,
    parameter int FW = ADR_W,
    parameter int SW = SHAMT_W
) (
    input  logic [OW-1:0] opcode,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] operand,
    input  logic [FW-1:0] field,
    output logic [DW-1:0] result,
    output logic          acc_we
);
    localparam int PAD_W = DW - FW;

    logic [DW-1:0] imm_ext;
    logic [SW-1:0] shamt;

    assign imm_ext = {{PAD_W{1'b0}}, field};
    assign shamt   = field[SW-1:0];

    always_comb begin
        result = acc;
        acc_we = 1'b1;
        case (opcode)
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            OP_LOAD: result = operand;
            OP_XOR:  result = acc ^ operand;
            OP_OR:   result = acc | operand;
            OP_AND:  result = acc & operand;
            OP_ADDI: result = acc + imm_ext;
            OP_SHL:  result = acc << shamt;
            OP_SHR:  result = acc >> shamt;
            default: acc_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
    import acc_cpu_pkg::*;
#(
    parameter int DW = ACC_W,
    parameter int OW = OPC_W
) (
    input  logic [OW-1:0] opcode,
    input  logic [DW-1:0] acc,
    output logic          take
);
    logic is_neg;
    logic is_zero;
    logic is_pos;

    assign is_neg  = acc[DW-1];
    assign is_zero = (acc == '0);
    assign is_pos  = !is_neg && !is_zero;

    always_comb begin
        case (opcode)
            OP_JUMP:  take = 1'b1;
            OP_JNEG:  take = is_neg;
            OP_JPOS:  take = is_pos;
            OP_JZERO: take = is_zero;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_mar_sel.sv
module acc_cpu_mar_sel
    import acc_cpu_pkg::*;
#(
    parameter int AW = ADR_W
) (
    input  cpu_state_e    state,
    input  logic [AW-1:0] mar_cur,
    input  logic [AW-1:0] fetched_field,
    input  logic [AW-1:0] next_pc,
    output logic [AW-1:0] mar_nxt
);
    always_comb begin
        case (state)
            ST_IRLD: mar_nxt = fetched_field;
            ST_EXEC: mar_nxt = next_pc;
            default: mar_nxt = mar_cur;
        endcase
    end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [ADR_W-1:0] mem_addr,
    output logic [ACC_W-1:0] mem_wdata,
    output logic             mem_we,
    input  logic [ACC_W-1:0] mem_rdata,
    output logic [OUT_W-1:0] out_port
);
    localparam int OPC_LSB = ACC_W - OPC_W;

    cpu_regs_t r_q;
    cpu_regs_t r_d;

    logic [OPC_W-1:0] opcode;
    logic [ADR_W-1:0] field;
    logic             is_exec;
    logic [ACC_W-1:0] alu_res;
    logic             alu_we;
    logic             br_take;
    logic [ADR_W-1:0] pc_after;
    logic [ADR_W-1:0] mar_nxt;

    assign opcode  = r_q.ir[ACC_W-1:OPC_LSB];
    assign field   = r_q.ir[ADR_W-1:0];
    assign is_exec = (r_q.state == ST_EXEC);

    acc_cpu_alu #(.DW(ACC_W), .OW(OPC_W), .FW(ADR_W), .SW(SHAMT_W)) u_alu (
        .opcode (opcode),
        .acc    (r_q.ac),
        .operand(mem_rdata),
        .field  (field),
        .result (alu_res),
        .acc_we (alu_we)
    );

    acc_cpu_branch #(.DW(ACC_W), .OW(OPC_W)) u_branch (
        .opcode(opcode),
        .acc   (r_q.ac),
        .take  (br_take)
    );

    assign pc_after = br_take ? field : r_q.pc;

    acc_cpu_mar_sel #(.AW(ADR_W)) u_mar_sel (
        .state        (r_q.state),
        .mar_cur      (r_q.mar),
        .fetched_field(mem_rdata[ADR_W-1:0]),
        .next_pc      (pc_after),
        .mar_nxt      (mar_nxt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.mar = mar_nxt;
        case (r_q.state)
            ST_FETCH: begin
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = ST_IRLD;
            end
            ST_IRLD: begin
                r_d.mdr   = mem_rdata;
                r_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.ir    = r_q.mdr;
                r_d.state = ST_EXEC;
            end
            default: begin
                r_d.mdr = mem_rdata;
                if (alu_we) begin
                    r_d.ac = alu_res;
                end
                if (opcode == OP_OUT) begin
                    r_d.outr = r_q.ac[OUT_W-1:0];
                end
                r_d.pc    = pc_after;
                r_d.state = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_wdata = r_q.ac;
    assign mem_we    = is_exec && (opcode == OP_STORE);
    assign out_port  = r_q.outr;

    p_seq_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DECODE) |=> (r_q.state == ST_EXEC));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FETCH) |=> (r_q.pc == $past(r_q.pc) + 8'd1));

    p_operand_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_exec |-> (mem_addr == field));

    p_write_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exec && opcode == OP_JUMP) |=> (r_q.pc == $past(field)));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_exec && opcode == OP_OUT) |=> $stable(out_port));

    p_acc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_exec |=> $stable(r_q.ac));

endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic [7:0]  out_port;

    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = 8'h00;
    logic [15:0] ld_data = 16'h0000;
    logic [15:0] mem [256];

    int checks = 0;
    int errors = 0;

    localparam logic [15:0] SENT = 16'hDEAD;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .mem_rdata(mem_rdata),
        .out_port (out_port)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic go(input int n);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_alu(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            8'h00: return a + b;
            8'h05: return a - b;
            8'h06: return a ^ b;
            8'h07: return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic bit exp_take(input logic [7:0] op, input logic [15:0] a);
        if (op == 8'h04) return $signed(a) < 0;
        if (op == 8'h09) return $signed(a) > 0;
        return a == 16'h0000;
    endfunction

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h1234, 16'h00FF, 16'hA5A5};
    logic [7:0]  alu_ops [5] = '{8'h00, 8'h05, 8'h06, 8'h07, 8'h08};
    logic [7:0]  br_ops [3]  = '{8'h04, 8'h09, 8'h0A};

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: got %h expected %h", 1'b1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 and R2: reset values and four-cycle address sequence
        hold_reset();
        put(8'h00, 16'h0130);
        put(8'h01, 16'h0301);
        put(8'h30, SENT);
        check("R1 addr in reset", {8'h00, mem_addr}, 16'h0000);
        check("R1 we in reset", {15'd0, mem_we}, 16'h0000);
        check("R1 out in reset", {8'h00, out_port}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 addr cycle2", {8'h00, mem_addr}, 16'h0000);
        check("R3 we cycle2", {15'd0, mem_we}, 16'h0000);
        @(negedge clk);
        check("R2 addr cycle3", {8'h00, mem_addr}, 16'h0030);
        check("R3 we cycle3", {15'd0, mem_we}, 16'h0000);
        @(negedge clk);
        check("R3 we cycle4", {15'd0, mem_we}, 16'h0001);
        check("R2 addr cycle4", {8'h00, mem_addr}, 16'h0030);
        check("R1 ac zero on wdata", mem_wdata, 16'h0000);
        @(negedge clk);
        check("R3 we cycle5", {15'd0, mem_we}, 16'h0000);
        check("R2 addr next pc", {8'h00, mem_addr}, 16'h0001);
        repeat (4) @(negedge clk);
        check("R1 stored zero", mem[8'h30], 16'h0000);

        // R4 R5 R3: arithmetic and bitwise sweep through LOAD/STORE
        foreach (alu_ops[k]) begin
            foreach (vals[i]) begin
                foreach (vals[j]) begin
                    hold_reset();
                    put(8'h00, 16'h0211);
                    put(8'h01, {alu_ops[k], 8'h12});
                    put(8'h02, 16'h0110);
                    put(8'h03, 16'h0303);
                    put(8'h11, vals[i]);
                    put(8'h12, vals[j]);
                    put(8'h10, SENT);
                    go(20);
                    check((k < 2) ? "R4 add/sub R3" : "R5 bitwise R3", mem[8'h10],
                          exp_alu(alu_ops[k], vals[i], vals[j]));
                end
            end
        end

        // R6: immediate add, zero-extended
        foreach (vals[i]) begin
            for (int m = 0; m < 8; m++) begin
                logic [7:0] imm;
                imm = 8'(m * 37 + 3);
                if (m == 7) imm = 8'hFF;
                hold_reset();
                put(8'h00, 16'h0211);
                put(8'h01, {8'h0B, imm});
                put(8'h02, 16'h0110);
                put(8'h03, 16'h0303);
                put(8'h11, vals[i]);
                put(8'h10, SENT);
                go(20);
                check("R6 addi", mem[8'h10], vals[i] + {8'h00, imm});
            end
        end

        // R7: shifts by every amount
        for (int s = 0; s < 2; s++) begin
            foreach (vals[i]) begin
                for (int n = 0; n < 16; n++) begin
                    hold_reset();
                    put(8'h00, 16'h0211);
                    put(8'h01, {(s == 0) ? 8'h0D : 8'h0E, 4'h0, 4'(n)});
                    put(8'h02, 16'h0110);
                    put(8'h03, 16'h0303);
                    put(8'h11, vals[i]);
                    put(8'h10, SENT);
                    go(20);
                    check("R7 shift", mem[8'h10],
                          (s == 0) ? (vals[i] << n) : (vals[i] >> n));
                end
            end
        end

        // R9 and R8: branches choose between two marker stores
        for (int b = 0; b < 4; b++) begin
            foreach (vals[i]) begin
                logic [7:0] op;
                bit tk;
                op = (b < 3) ? br_ops[b] : 8'h03;
                tk = (b < 3) ? exp_take(op, vals[i]) : 1'b1;
                hold_reset();
                put(8'h00, 16'h0211);
                put(8'h01, {op, 8'h05});
                put(8'h02, 16'h0213);
                put(8'h03, 16'h0110);
                put(8'h04, 16'h0304);
                put(8'h05, 16'h0214);
                put(8'h06, 16'h0110);
                put(8'h07, 16'h0307);
                put(8'h11, vals[i]);
                put(8'h13, 16'hAAAA);
                put(8'h14, 16'hBBBB);
                put(8'h10, SENT);
                go(28);
                check((b < 3) ? "R9 cond branch" : "R8 jump", mem[8'h10],
                      tk ? 16'hBBBB : 16'hAAAA);
            end
        end

        // R10: output port takes low byte only at OUT
        foreach (vals[i]) begin
            hold_reset();
            put(8'h00, 16'h0211);
            put(8'h01, 16'h0C00);
            put(8'h02, 16'h0302);
            put(8'h11, vals[i]);
            go(6);
            check("R10 out before OUT", {8'h00, out_port}, 16'h0000);
            repeat (6) @(negedge clk);
            check("R10 out low byte", {8'h00, out_port}, {8'h00, vals[i][7:0]});
        end

        // R11: undefined opcodes leave accumulator, memory and port alone
        for (int op = 16'h0F; op <= 16'hFF; op++) begin
            hold_reset();
            put(8'h00, 16'h0211);
            put(8'h01, {8'(op), 8'h12});
            put(8'h02, 16'h0110);
            put(8'h03, 16'h0303);
            put(8'h11, 16'h5A3C);
            put(8'h12, 16'h0F0F);
            put(8'h10, SENT);
            go(20);
            check("R11 acc kept", mem[8'h10], 16'h5A3C);
            check("R11 mem kept", mem[8'h12], 16'h0F0F);
            if (op[3:0] == 4'h0) check("R11 out kept", {8'h00, out_port}, 16'h0000);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule